// File: doc/BRIEF.md
# Serial Register Port with Shared Data Line

This block is the slave end of a three-wire control port: a serial clock, one data line shared by both directions, and an active-low frame enable. Each frame carries a device code, a direction flag, a register number and a 16-bit word. A write frame loads one of four control words, which are presented as parallel outputs. A read frame hands the data line to the slave after a half-cycle turnaround. The slave then shifts out a status word, one half of a fixed 32-bit identity code, or zero.

The serial pins are oversampled by a fast system clock. Every action of the port happens on that clock. The data line is modelled as three separate signals: an input, an output and an output enable. The enclosing pad, or a testbench, forms the shared wire from them and can check that only one side drives it at a time.

Top module: `ser_reg_port`

## Requirements
- R1: A frame is shifted most significant bit first. It holds 25 bits in this order: a 3-bit device code, a direction bit (1 = read, 0 = write), a 5-bit register number and a 16-bit data word. The master sets each bit after a falling serial clock edge, and the slave samples it on the rising edge.
- R2: Only device code 101b is answered. With any other code, `ser_dat_oe` stays low for the whole frame and no control word changes.
- R3: A write takes effect on the first falling serial clock edge after the enable returns high. Before that edge the control outputs keep their old value.
- R4: In a read frame, `ser_dat_oe` stays low through the half clock that follows the rising edge sampling the last register-number bit. The slave starts driving on the next rising edge. It presents D15 first and then one new bit on each rising edge, for 16 bits in total.
- R5: Once the enable is high, `ser_dat_oe` is low no later than the falling edge of the next serial clock pulse.
- R6: Register 3 reads as the `rssi_lvl` input, zero-extended into bits 6:0.
- R7: Registers 30 and 31 read 0x825D and 0x10B9, the low and high halves of the identity code 0x10B9825D. Writes to them, and to register 3, change nothing.
- R8: Registers 4 to 7 are write-only. Register 4+k appears on `ctrl_flat[16k+15:16k]`, and reading any of them returns 0x0000.
- R9: Every other register number reads 0x0000 and ignores writes.
- R10: After reset all control words are zero and `ser_dat_oe` is low.
- R11: A write frame that ends with fewer than 25 bits changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the master, idle low |
| ser_en_n | input | 1 | Active-low frame enable |
| ser_dat_i | input | 1 | Data line as seen at the pin |
| ser_dat_o | output | 1 | Data bit driven by the slave during a read |
| ser_dat_oe | output | 1 | High while the slave drives the data line |
| rssi_lvl | input | 7 | Signal-strength status returned by register 3 |
| ctrl_flat | output | 64 | Four control words, register 4 in the low 16 bits |

## Verification
The assertions rely on the master moving the serial pins slowly compared with the system clock. Each serial half period must span several system clocks, so that every edge is seen once after synchronization. They also assume the enable never changes in the same system cycle as a serial clock edge. The stimulus uses a serial half period of eight system clocks and changes the enable only while the serial clock is steady low. It releases the data line during the turnaround and reclaims it only after the post-frame clock pulse. A contention monitor flags any cycle in which the master and the slave drive the line together.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
  localparam int DEV_W      = 3;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int HDR_BITS   = DEV_W + 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int N_CTRL     = 4;

  localparam logic [DEV_W-1:0]    DEV_CODE  = 3'b101;
  localparam logic [ADDR_W-1:0]   ADR_RSSI  = 5'd3;
  localparam logic [ADDR_W-1:0]   ADR_CTRL0 = 5'd4;
  localparam logic [ADDR_W-1:0]   ADR_ID_LO = 5'd30;
  localparam logic [ADDR_W-1:0]   ADR_ID_HI = 5'd31;
  localparam logic [2*DATA_W-1:0] ID_WORD   = 32'h10B9_825D;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {STAGES{RST_VAL[b]}};
      else     pipe <= {pipe[STAGES-2:0], d[b]};
    end
    assign q[b] = pipe[STAGES-1];
  end
endmodule

// File: rtl/sp_regs.sv
module sp_regs
  import ser_port_pkg::*;
#(
  parameter int RSSI_W = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [RSSI_W-1:0]             rssi,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_word,
  input  logic                          wr_stb,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [N_CTRL-1:0][DATA_W-1:0] ctrl_q
);
  localparam logic [ADDR_W-1:0] ADR_CTRL_END = ADR_CTRL0 + ADDR_W'(N_CTRL);

  logic [DATA_W-1:0] rd_mux;

  // read side: status, identity halves, zero for everything else
  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      ADR_RSSI:  rd_mux = DATA_W'(rssi);
      ADR_ID_LO: rd_mux = ID_WORD[DATA_W-1:0];
      ADR_ID_HI: rd_mux = ID_WORD[2*DATA_W-1:DATA_W];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_word <= '0;
    else     rd_word <= rd_mux;
  end

  // write side: one register per control word
  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    localparam logic [ADDR_W-1:0] MY_ADR = ADR_CTRL0 + ADDR_W'(g);
    always_ff @(posedge clk) begin
      if (rst)                            ctrl_q[g] <= '0;
      else if (wr_stb && wr_addr == MY_ADR) ctrl_q[g] <= wr_data;
    end

    // R8
    wr_land_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && wr_addr == MY_ADR) |=> (ctrl_q[g] == $past(wr_data)));
  end

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !(wr_addr >= ADR_CTRL0 && wr_addr < ADR_CTRL_END)) |=> $stable(ctrl_q));
endmodule

// File: rtl/sp_frame.sv
module sp_frame
  import ser_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              en_n_s,
  input  logic              din_s,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout,
  output logic              oe
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_RW   = CNT_W'(DEV_W);
  localparam logic [CNT_W-1:0] CNT_ADR  = CNT_W'(DEV_W + ADDR_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic              sclk_d, en_n_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg, rd_sh;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, dev_ok_q, wr_pend, oe_q, dout_q, wr_stb_q;

  wire sclk_rise = sclk_s & ~sclk_d;
  wire sclk_fall = ~sclk_s & sclk_d;
  wire fr_start  = en_n_d & ~en_n_s;
  wire fr_end    = ~en_n_d & en_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      en_n_d   <= 1'b1;
      bit_cnt  <= '0;
      shreg    <= '0;
      rd_sh    <= '0;
      addr_q   <= '0;
      rd_q     <= 1'b0;
      dev_ok_q <= 1'b0;
      wr_pend  <= 1'b0;
      oe_q     <= 1'b0;
      dout_q   <= 1'b0;
      wr_stb_q <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      en_n_d   <= en_n_s;
      wr_stb_q <= 1'b0;
      if (fr_start) begin
        bit_cnt  <= '0;
        rd_q     <= 1'b0;
        dev_ok_q <= 1'b0;
        wr_pend  <= 1'b0;
      end else if (!en_n_s) begin
        if (sclk_rise && bit_cnt < CNT_FULL) begin
          bit_cnt <= bit_cnt + 1'b1;
          shreg   <= {shreg[DATA_W-2:0], din_s};
          if (bit_cnt == CNT_RW) begin
            rd_q     <= din_s;
            dev_ok_q <= (shreg[DEV_W-1:0] == DEV_CODE);
          end
          if (bit_cnt == CNT_ADR)
            addr_q <= {shreg[ADDR_W-2:0], din_s};
          if (bit_cnt == CNT_HDR && rd_q && dev_ok_q) begin
            oe_q   <= 1'b1;
            dout_q <= rd_word[DATA_W-1];
            rd_sh  <= {rd_word[DATA_W-2:0], 1'b0};
          end else if (bit_cnt > CNT_HDR && oe_q) begin
            dout_q <= rd_sh[DATA_W-1];
            rd_sh  <= {rd_sh[DATA_W-2:0], 1'b0};
          end
        end
      end else begin
        oe_q   <= 1'b0;
        dout_q <= 1'b0;
        if (fr_end)
          wr_pend <= (bit_cnt == CNT_FULL) && !rd_q && dev_ok_q;
        else if (sclk_fall && wr_pend) begin
          wr_stb_q <= 1'b1;
          wr_pend  <= 1'b0;
        end
      end
    end
  end

  assign reg_addr = addr_q;
  assign wr_stb   = wr_stb_q;
  assign wr_data  = shreg;
  assign dout     = dout_q;
  assign oe       = oe_q;

  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    en_n_s |=> !oe_q);

  // R2
  oe_dev_chk: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (dev_ok_q && rd_q));

  // R3
  wr_after_en_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb_q |-> ($past(en_n_s) && $past(sclk_fall)));

  // R4
  oe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> ($past(sclk_rise) && $past(bit_cnt) == CNT_HDR));
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import ser_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RSSI_W = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_clk,
  input  logic                     ser_en_n,
  input  logic                     ser_dat_i,
  output logic                     ser_dat_o,
  output logic                     ser_dat_oe,
  input  logic [RSSI_W-1:0]        rssi_lvl,
  output logic [N_CTRL*DATA_W-1:0] ctrl_flat
);
  logic [2:0]                  pins_s;
  logic [DATA_W-1:0]           rd_word, wr_data;
  logic [ADDR_W-1:0]           reg_addr;
  logic                        wr_stb;
  logic [N_CTRL-1:0][DATA_W-1:0] ctrl_q;

  sp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d({ser_clk, ser_en_n, ser_dat_i}),
    .q(pins_s)
  );

  sp_frame u_frame (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[2]), .en_n_s(pins_s[1]), .din_s(pins_s[0]),
    .rd_word(rd_word), .reg_addr(reg_addr),
    .wr_stb(wr_stb), .wr_data(wr_data),
    .dout(ser_dat_o), .oe(ser_dat_oe)
  );

  sp_regs #(.RSSI_W(RSSI_W)) u_regs (
    .clk(clk), .rst(rst), .rssi(rssi_lvl),
    .rd_addr(reg_addr), .rd_word(rd_word),
    .wr_stb(wr_stb), .wr_addr(reg_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q)
  );

  assign ctrl_flat = ctrl_q;
endmodule

// File: tb/tb_ser_reg_port.sv
module tb_ser_reg_port;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_en_n = 1'b1;
  logic        m_drv = 1'b1;
  logic        m_dat = 1'b0;
  logic [6:0]  rssi = '0;
  logic        ser_dat_o, ser_dat_oe;
  logic [63:0] ctrl_flat;
  wire         line = m_drv ? m_dat : (ser_dat_oe ? ser_dat_o : 1'b1);

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit oe_seen = 0;
  int nb = 0;
  logic [15:0] cap = '0;
  logic [15:0] q_dat[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  ser_reg_port dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
    .ser_dat_i(line), .ser_dat_o(ser_dat_o), .ser_dat_oe(ser_dat_oe),
    .rssi_lvl(rssi), .ctrl_flat(ctrl_flat)
  );

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input int k);
    return ctrl_flat[16*k +: 16];
  endfunction

  // monitor: collect bits the slave drives, compare on frame end
  always @(negedge ser_en_n) begin nb = 0; cap = '0; end
  always @(negedge ser_clk) if (ser_dat_oe) begin cap = {cap[14:0], ser_dat_o}; nb++; end
  always @(posedge ser_en_n) begin
    if (nb != 0 || q_dat.size() != 0) begin
      if (q_dat.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected read data actual=%h expected=none", cap);
      end else begin
        logic [15:0] e;
        string t;
        e = q_dat.pop_front();
        t = q_tag.pop_front();
        chk16({t, " read word"}, cap, e);
        chk16("R4 bits driven", 16'(nb), 16'd16);
      end
    end
  end

  // contention monitor
  always @(negedge clk) begin
    if (ser_dat_oe) oe_seen = 1;
    if (!rst && m_drv && ser_dat_oe) begin
      checks++; errors++;
      $display("FAIL R4 contention actual=oe1 expected=oe0");
    end
  end

  task automatic frame_body(input logic [2:0] dev, input logic rw, input logic [4:0] adr,
                            input logic [15:0] dat, input int nbits);
    logic [24:0] vec;
    vec = {dev, rw, adr, dat};
    ser_en_n = 1'b0;
    hw(H);
    for (int i = 0; i < nbits; i++) begin
      if (i < 9 || !rw) begin m_drv = 1'b1; m_dat = vec[24-i]; end
      hw(H);
      ser_clk = 1'b1;
      hw(H);
      ser_clk = 1'b0;
      if (rw && i == 8) begin
        m_drv = 1'b0;
        hw(H/2);
        chk1("R4 turnaround oe", ser_dat_oe, 1'b0);
      end
    end
  endtask

  task automatic frame_end();
    ser_en_n = 1'b1;
    hw(H);
  endtask

  task automatic frame_pulse();
    ser_clk = 1'b1;
    hw(H);
    ser_clk = 1'b0;
    chk1("R5 oe released", ser_dat_oe, 1'b0);
    m_drv = 1'b1;
    hw(2*H);
  endtask

  task automatic wr(input logic [2:0] dev, input logic [4:0] adr, input logic [15:0] dat);
    frame_body(dev, 1'b0, adr, dat, 25);
    frame_end();
    frame_pulse();
  endtask

  task automatic rd(input logic [2:0] dev, input logic [4:0] adr,
                    input logic [15:0] exp, input string tag);
    if (dev == 3'b101) begin q_dat.push_back(exp); q_tag.push_back(tag); end
    frame_body(dev, 1'b1, adr, 16'h0, 25);
    frame_end();
    frame_pulse();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    hw(5);
    rst = 1'b0;
    hw(5);
    // R10 reset state
    chk16("R10 ctrl reg4", cw(0), 16'h0);
    chk16("R10 ctrl reg7", cw(3), 16'h0);
    chk1("R10 oe", ser_dat_oe, 1'b0);

    // R1 R3 write commit timing
    frame_body(3'b101, 1'b0, 5'd4, 16'hA5C3, 25);
    frame_end();
    chk16("R3 before falling edge", cw(0), 16'h0000);
    frame_pulse();
    chk16("R1 write reg4", cw(0), 16'hA5C3);

    // R8 other control words
    wr(3'b101, 5'd5, 16'h1234);
    wr(3'b101, 5'd6, 16'hFFFF);
    wr(3'b101, 5'd7, 16'h8001);
    chk16("R8 reg5", cw(1), 16'h1234);
    chk16("R8 reg6", cw(2), 16'hFFFF);
    chk16("R8 reg7", cw(3), 16'h8001);
    rd(3'b101, 5'd4, 16'h0000, "R8 read reg4");
    rd(3'b101, 5'd7, 16'h0000, "R8 read reg7");

    // R6 status register
    rssi = 7'h35;
    rd(3'b101, 5'd3, 16'h0035, "R6 rssi 35");
    rssi = 7'h7F;
    rd(3'b101, 5'd3, 16'h007F, "R6 rssi 7f");

    // R7 identity code
    rd(3'b101, 5'd30, 16'h825D, "R7 id low");
    rd(3'b101, 5'd31, 16'h10B9, "R7 id high");
    wr(3'b101, 5'd30, 16'h0000);
    wr(3'b101, 5'd3, 16'hFFFF);
    chk16("R7 ro write reg4", cw(0), 16'hA5C3);
    chk16("R7 ro write reg7", cw(3), 16'h8001);
    rd(3'b101, 5'd30, 16'h825D, "R7 id low after write");

    // R9 unimplemented address
    wr(3'b101, 5'd12, 16'h5555);
    chk16("R9 reg4 kept", cw(0), 16'hA5C3);
    chk16("R9 reg5 kept", cw(1), 16'h1234);
    chk16("R9 reg6 kept", cw(2), 16'hFFFF);
    chk16("R9 reg7 kept", cw(3), 16'h8001);
    rd(3'b101, 5'd12, 16'h0000, "R9 read unimplemented");

    // R2 foreign device code
    wr(3'b100, 5'd4, 16'h0000);
    chk16("R2 foreign write", cw(0), 16'hA5C3);
    oe_seen = 0;
    rd(3'b111, 5'd30, 16'h0000, "R2 foreign read");
    chk1("R2 oe stayed low", oe_seen, 1'b0);

    // R11 truncated frame
    frame_body(3'b101, 1'b0, 5'd4, 16'h0000, 20);
    frame_end();
    frame_pulse();
    chk16("R11 truncated write", cw(0), 16'hA5C3);
    wr(3'b101, 5'd4, 16'h0F0F);
    chk16("R11 recovery write", cw(0), 16'h0F0F);

    chk16("R4 queue drained", 16'(q_dat.size()), 16'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule